// File: doc/BRIEF.md
# Narrow Flash Word-Assembly Sequencer

This block sits between a 32-bit bus master and a non-volatile memory whose data path is only 16 bits wide. Each master read is turned into the right number of 16-bit memory beats, one beat per clock. A 32-bit word is built from two beats at consecutive halfword addresses, with the lower address giving the low half. A 16-bit instruction or halfword read takes a single beat.

Instruction fetches run back to back with no idle time. Data reads are framed by dead cycles: a single read has one idle cycle before its beats and one after. A burst of N words has N idle cycles before and N after. The master holds a request until it sees the one-cycle ready pulse. Each finished word is flagged with its own one-cycle valid strobe, so a burst delivers N strobes and one ready.

Top module: `flash_beat_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle. In the cycle after a reset edge, `mem_en`, `rsp_valid` and `req_ready` are all low.
- R2: A 32-bit fetch (`req_is_data`=0, `req_wide`=1) makes two beats in the two cycles after acceptance, at halfword addresses A and A+1, where A is `req_addr` shifted right by one. In the second beat, `rsp_valid` and `req_ready` are high and `rsp_data` = {beat at A+1, beat at A}.
- R3: A 16-bit fetch (`req_wide`=0) makes one beat in the cycle after acceptance. In that beat, `rsp_valid` and `req_ready` are high and `rsp_data` = {16'h0000, beat}.
- R4: A single-word data read (`req_is_data`=1, count 1) has one idle cycle (`mem_en` low) before its beats and one after. `req_ready` pulses in the trailing idle cycle.
- R5: A data burst of N words has N leading idle cycles, then 2N beats (32-bit) or N beats (16-bit) at rising halfword addresses, then N trailing idle cycles. `rsp_valid` pulses once per word, on the word's last beat.
- R6: For data reads, `req_count` = 0 acts as 1 and values above 16 act as 16. For fetches, `req_count` is ignored and one word is read.
- R7: `req_ready` is high for exactly one cycle per request. The cycle after it is an idle accept cycle. No beat occurs while idle.
- R8: Width, kind, count and address are captured when the request is accepted. Changes to `req_wide` during the sequence have no effect on beats or data.
- R9: A reset in the middle of a request abandons it. No further beats or strobes appear until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master read request, held until ready |
| req_is_data | input | 1 | 1 = data read with dead cycles, 0 = instruction fetch |
| req_wide | input | 1 | 1 = 32-bit words, 0 = 16-bit |
| req_count | input | 5 | Words in a data burst (0 acts as 1, clamped to 16) |
| req_addr | input | 20 | Byte address of first word |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_valid | output | 1 | Assembled word valid this cycle |
| rsp_data | output | 32 | Assembled word |
| mem_en | output | 1 | Memory beat enable |
| mem_addr | output | 19 | Halfword address of current beat |
| mem_rdata | input | 16 | Memory read data for the enabled beat |

## Verification
Requests are issued back to back and with idle gaps. The mix covers 32-bit and 16-bit fetches, single data reads, and bursts of 3, 16, zero and over-range counts. Fetch against data separates the dead-cycle framing from the beat count. Wide against narrow at the same address separates the halves and checks their order. Bursts check that dead time scales with N and that the address keeps stepping across word boundaries. A mid-request width flip and a mid-burst reset test that inputs are captured at acceptance and that a reset abandons the request.

// File: rtl/flash_beat_seq.sv
module flash_beat_seq #(
  parameter int AW = 20,
  parameter int MAXW = 16,
  localparam int CW = $clog2(MAXW + 1),
  localparam int HW = AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_is_data,
  input  logic          req_wide,
  input  logic [CW-1:0] req_count,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          mem_en,
  output logic [HW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_BEAT, S_POST} st_t;

  st_t           st;
  logic          data_q, wide_q, hi_q;
  logic [CW-1:0] n_q, cnt_q, words_q;
  logic [15:0]   lo_q;
  logic [HW-1:0] ha_q;
  logic [CW-1:0] n_in;
  logic          word_done;

  assign n_in = !req_is_data ? CW'(1) :
                (req_count == '0) ? CW'(1) :
                (req_count > CW'(MAXW)) ? CW'(MAXW) : req_count;

  assign word_done = (st == S_BEAT) && (!wide_q || hi_q);
  assign mem_en    = (st == S_BEAT);
  assign mem_addr  = ha_q;
  assign rsp_valid = word_done;
  assign rsp_data  = wide_q ? {mem_rdata, lo_q} : {16'h0000, mem_rdata};
  assign req_ready = ((st == S_POST) && (cnt_q == CW'(1))) ||
                     (word_done && (words_q == CW'(1)) && !data_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      data_q  <= 1'b0;
      wide_q  <= 1'b0;
      hi_q    <= 1'b0;
      n_q     <= '0;
      cnt_q   <= '0;
      words_q <= '0;
      lo_q    <= '0;
      ha_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          data_q  <= req_is_data;
          wide_q  <= req_wide;
          n_q     <= n_in;
          cnt_q   <= n_in;
          words_q <= n_in;
          hi_q    <= 1'b0;
          ha_q    <= req_addr[AW-1:1];
          st      <= req_is_data ? S_PRE : S_BEAT;
        end
        S_PRE: begin
          if (cnt_q == CW'(1)) st <= S_BEAT;
          else cnt_q <= cnt_q - CW'(1);
        end
        S_BEAT: begin
          ha_q <= ha_q + HW'(1);
          if (wide_q && !hi_q) begin
            lo_q <= mem_rdata;
            hi_q <= 1'b1;
          end else begin
            hi_q    <= 1'b0;
            words_q <= words_q - CW'(1);
            if (words_q == CW'(1)) begin
              if (data_q) begin
                st    <= S_POST;
                cnt_q <= n_q;
              end else begin
                st <= S_IDLE;
              end
            end
          end
        end
        S_POST: begin
          if (cnt_q == CW'(1)) st <= S_IDLE;
          else cnt_q <= cnt_q - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_beat_seq_chk.sv
module flash_beat_seq_chk #(
  parameter int HW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_en,
  input logic [HW-1:0] mem_addr
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk)
    if (rst_q && !rst)
      a_r1_reset_idle: assert (!mem_en && !rsp_valid && !req_ready);

  a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  a_r7_idle_after_ready: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !mem_en);

  a_r5_valid_on_beat: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> mem_en);

  a_r2_half_pair: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !rsp_valid) |=> (mem_en && mem_addr == $past(mem_addr) + HW'(1)));
endmodule

bind flash_beat_seq flash_beat_seq_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_en(mem_en), .mem_addr(mem_addr)
);

// File: tb/flash_beat_seq_tb.sv
module flash_beat_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_is_data = 1'b0, req_wide = 1'b0;
  logic [4:0]  req_count = '0;
  logic [19:0] req_addr = '0;
  logic        req_ready, rsp_valid, mem_en;
  logic [31:0] rsp_data;
  logic [18:0] mem_addr;
  logic [15:0] mem_rdata;

  int vecs = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] mval(input logic [18:0] a);
    return 16'((int'(a) * 40503) ^ 16'h3C5A);
  endfunction
  assign mem_rdata = mval(mem_addr);

  flash_beat_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_data(req_is_data),
    .req_wide(req_wide), .req_count(req_count), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic        en;
    logic [18:0] addr;
    logic        vld;
    logic [31:0] data;
    logic        rdy;
  } cyc_t;

  cyc_t exq[$];

  task automatic check_now(input string tag, input cyc_t e);
    cyc_t a;
    a.en = mem_en; a.addr = mem_en ? mem_addr : '0;
    a.vld = rsp_valid; a.data = rsp_valid ? rsp_data : '0; a.rdy = req_ready;
    vecs++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s t=%0t en/addr/vld/data/rdy act=%b/%h/%b/%h/%b exp=%b/%h/%b/%h/%b",
               tag, $time, a.en, a.addr, a.vld, a.data, a.rdy,
               e.en, e.addr, e.vld, e.data, e.rdy);
    end
  endtask

  function automatic cyc_t idle_c(input logic rdy);
    cyc_t c; c = '0; c.rdy = rdy; return c;
  endfunction

  function automatic cyc_t beat_c(input logic [18:0] a, input logic v,
                                  input logic [31:0] d, input logic rdy);
    cyc_t c; c.en = 1'b1; c.addr = a; c.vld = v; c.data = v ? d : '0; c.rdy = rdy;
    return c;
  endfunction

  task automatic run_req(input string tag, input logic dat, input logic wide,
                         input logic [4:0] cnt, input logic [19:0] addr,
                         input bit flip);
    int n;
    logic [18:0] a;
    exq.delete();
    n = !dat ? 1 : (cnt == 0) ? 1 : (cnt > 16) ? 16 : int'(cnt);
    a = addr[19:1];
    exq.push_back(idle_c(1'b0));
    if (dat) for (int i = 0; i < n; i++) exq.push_back(idle_c(1'b0));
    for (int w = 0; w < n; w++) begin
      bit last_f;
      last_f = !dat && (w == n - 1);
      if (wide) begin
        exq.push_back(beat_c(a, 1'b0, '0, 1'b0));
        exq.push_back(beat_c(a + 19'd1, 1'b1, {mval(a + 19'd1), mval(a)}, last_f));
        a = a + 19'd2;
      end else begin
        exq.push_back(beat_c(a, 1'b1, {16'h0000, mval(a)}, last_f));
        a = a + 19'd1;
      end
    end
    if (dat) for (int i = 0; i < n; i++) exq.push_back(idle_c(i == n - 1));
    @(negedge clk);
    req_valid = 1'b1; req_is_data = dat; req_wide = wide;
    req_count = cnt; req_addr = addr;
    for (int i = 0; i < exq.size(); i++) begin
      if (i > 0) @(negedge clk);
      #1;
      check_now(tag, exq[i]);
      if (flip && i == 1) req_wide = ~req_wide;
    end
  endtask

  task automatic idle_gap(input int k);
    @(negedge clk);
    req_valid = 1'b0; req_wide = 1'b1; req_is_data = 1'b1;
    #1 check_now("R7", idle_c(1'b0));
    for (int i = 1; i < k; i++) begin
      @(negedge clk); #1 check_now("R7", idle_c(1'b0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check_now("R1", idle_c(1'b0));
    idle_gap(3);
    run_req("R2", 1'b0, 1'b1, 5'd0, 20'h01230, 1'b0);
    run_req("R3", 1'b0, 1'b0, 5'd0, 20'h01230, 1'b0);
    run_req("R3", 1'b0, 1'b0, 5'd0, 20'h01232, 1'b0);
    run_req("R6", 1'b0, 1'b1, 5'd9, 20'h00100, 1'b0);
    idle_gap(2);
    run_req("R4", 1'b1, 1'b1, 5'd1, 20'h04000, 1'b0);
    run_req("R4", 1'b1, 1'b0, 5'd1, 20'h04002, 1'b0);
    run_req("R5", 1'b1, 1'b1, 5'd3, 20'h08000, 1'b0);
    run_req("R5", 1'b1, 1'b0, 5'd3, 20'h0800A, 1'b0);
    run_req("R5", 1'b1, 1'b1, 5'd16, 20'hFFFF0, 1'b0);
    run_req("R6", 1'b1, 1'b1, 5'd0, 20'h02000, 1'b0);
    run_req("R6", 1'b1, 1'b0, 5'd25, 20'h03000, 1'b0);
    run_req("R8", 1'b0, 1'b1, 5'd0, 20'h05554, 1'b1);
    run_req("R8", 1'b1, 1'b0, 5'd2, 20'h06000, 1'b1);
    idle_gap(2);
    @(negedge clk);
    req_valid = 1'b1; req_is_data = 1'b1; req_wide = 1'b1;
    req_count = 5'd4; req_addr = 20'h07000;
    repeat (7) @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    #1 check_now("R1", idle_c(1'b0));
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1 check_now("R9", idle_c(1'b0));
    end
    run_req("R9", 1'b0, 1'b1, 5'd0, 20'h00010, 1'b0);
    idle_gap(2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule